// File: doc/BRIEF.md
# Byte-Loadable Quad-Channel DAC Write Port

This block is the digital front end for four 14-bit converter channels that are written over a microprocessor bus. A host places a code on the data bus, picks a channel with the address lines and pulses write while chip select is low. The code is committed on the rising edge of write. Each channel has two stages of storage: an input register that takes bus writes, and a DAC latch that feeds the converter. A load input copies the input registers into the latches.

A host with a narrow bus can build a 14-bit code in two bus cycles. A byte-shift input steers an 8-bit bus value into either the low eight bits or the top six bits of the input register. One address line sends a write to all four channels at once. Load can be held high while several channels are written and then pulsed low to move all of them together. It can also be held low so that each write reaches its latch immediately. A clear input puts two channel pairs into a clear state. Each pair stays there until load is taken low after clear has been released.

All control inputs are synchronized to the system clock before use. The write edge is detected from the synchronized write signal.

Top module: `dac_quad_loader`

## Requirements
- R1: An input register is written only when the synchronized write goes from low to high and chip select was low in the cycle before that edge. The data, address and byte-shift values used are the ones present in that cycle. A write pulse with chip select high changes nothing.
- R2: With `narrow_bus` low, the whole 14-bit bus value is stored. Bus bit 13 is the most significant bit.
- R3: With `narrow_bus` high and `byte_shift` high, bus bits 7..0 replace register bits 7..0, and register bits 13..8 keep their value.
- R4: With `narrow_bus` high and `byte_shift` low, bus bits 5..0 replace register bits 13..8. Register bits 7..0 keep their value. Bus bits 7..6 are ignored.
- R5: With `addr[2]` low, `addr[1:0]` = 0, 1, 2, 3 selects channel 0, 1, 2, 3. With `addr[2]` high, all four channels are written and `addr[1:0]` is ignored.
- R6: While `load_n` is high, or while `clear_n` is low, the DAC latches keep their value, even when input registers are written.
- R7: While `load_n` is low and `clear_n` is high, every DAC latch takes its input register value. A write made in this state reaches the addressed latch in the same cycle as its input register.
- R8: While `clear_n` is low, both clear flags are set. Channels 0 and 1 form group A, and channels 2 and 3 form group B.
- R9: A clear flag that is set stays set until a cycle in which `load_n` is low and `clear_n` is high. That cycle clears it.
- R10: After reset, all input registers and latches are zero and both clear flags are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_data | input | 14 | Write data bus |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low; commits on rising edge |
| byte_shift | input | 1 | Byte mode: 1 low byte, 0 high six bits |
| narrow_bus | input | 1 | 1 selects two-cycle byte loading, 0 full-width loading |
| addr | input | 3 | [1:0] channel, [2] broadcast |
| load_n | input | 1 | Latch transfer, active low, level sensitive |
| clear_n | input | 1 | Clear request, active low, level sensitive |
| dac_code | output | 56 | DAC latches, channel k in bits 14k+13..14k |
| clr_grp_a | output | 1 | Clear state of channels 0 and 1 |
| clr_grp_b | output | 1 | Clear state of channels 2 and 3 |

## Verification
The assertions assume that data, address, byte-shift and bus width are stable around every write strobe. They rely on this because all inputs go through the same synchronizer depth, so the values captured in the cycle before the detected edge are the ones the host intended. The bench changes those inputs only while write is high and holds every level for several clocks, so the synchronizer never sees two controls move in a way that splits across a sampled edge. The broadcast assertion assumes nothing about the low address bits, and the sweep drives all eight address codes to match.

// File: rtl/dql_pkg.sv
package dql_pkg;
    parameter int CODE_W   = 14;
    parameter int NUM_CH   = 4;
    parameter int ADDR_W   = 3;
    parameter int BYTE_W   = 8;
    localparam int HIGH_W  = CODE_W - BYTE_W;
    localparam int NUM_GRP = NUM_CH / 2;
    localparam int SEL_W   = $clog2(NUM_CH);

    typedef enum logic [1:0] {
        WK_FULL = 2'd0,
        WK_LOW  = 2'd1,
        WK_HIGH = 2'd2
    } wkind_e;

    typedef struct packed {
        logic              cs_n;
        logic              wr_n;
        logic              shift;
        logic              narrow;
        logic              load_n;
        logic              clear_n;
        logic [ADDR_W-1:0] addr;
        logic [CODE_W-1:0] data;
    } bus_ctl_t;

    localparam bus_ctl_t CTL_IDLE = '{cs_n: 1'b1, wr_n: 1'b1, shift: 1'b1,
                                       narrow: 1'b0, load_n: 1'b1, clear_n: 1'b1,
                                       addr: '0, data: '0};
endpackage

// File: rtl/dql_sync.sv
module dql_sync
    import dql_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  bus_ctl_t raw,
    output bus_ctl_t synced
);
    bus_ctl_t pipe_q [STAGES];
    bus_ctl_t pipe_d [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb pipe_d[s] = raw;
            end else begin : g_next
                always_comb pipe_d[s] = pipe_q[s-1];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q[s] <= CTL_IDLE;
                else        pipe_q[s] <= pipe_d[s];
            end
        end
    endgenerate

    assign synced = pipe_q[STAGES-1];
endmodule

// File: rtl/dql_write_decode.sv
module dql_write_decode
    import dql_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  bus_ctl_t          cur,
    output logic [NUM_CH-1:0] ch_we,
    output wkind_e            kind,
    output logic [CODE_W-1:0] wdata
);
    typedef struct packed {
        bus_ctl_t prev;
    } dec_state_t;

    dec_state_t st_d, st_q;
    logic       commit;
    logic       bcast;

    always_comb begin
        st_d      = st_q;
        st_d.prev = cur;

        commit = !st_q.prev.cs_n && !st_q.prev.wr_n && cur.wr_n;
        bcast  = st_q.prev.addr[ADDR_W-1];

        ch_we = '0;
        if (commit) begin
            if (bcast) begin
                ch_we = '1;
            end else begin
                for (int c = 0; c < NUM_CH; c++) begin
                    if (st_q.prev.addr[SEL_W-1:0] == SEL_W'(c)) ch_we[c] = 1'b1;
                end
            end
        end

        if (!st_q.prev.narrow)    kind = WK_FULL;
        else if (st_q.prev.shift) kind = WK_LOW;
        else                      kind = WK_HIGH;

        wdata = st_q.prev.data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.prev <= CTL_IDLE;
        else        st_q      <= st_d;
    end

    assert_single_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.prev.addr[ADDR_W-1] |-> $onehot0(ch_we));
    assert_bcast_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.prev.addr[ADDR_W-1] && (ch_we != '0)) |-> (ch_we == '1));
    assert_no_write_without_cs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.prev.cs_n |-> (ch_we == '0));
endmodule

// File: rtl/dql_latch_bank.sv
module dql_latch_bank
    import dql_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CH-1:0]             ch_we,
    input  wkind_e                        kind,
    input  logic [CODE_W-1:0]             wdata,
    input  logic                          load_n,
    input  logic                          clear_n,
    output logic [NUM_CH-1:0][CODE_W-1:0] latch_out,
    output logic [NUM_GRP-1:0]            clr_flag
);
    typedef struct packed {
        logic [NUM_CH-1:0][CODE_W-1:0] inreg;
        logic [NUM_CH-1:0][CODE_W-1:0] latch;
        logic [NUM_GRP-1:0]            clr;
    } bank_state_t;

    bank_state_t st_d, st_q;
    logic        xfer;

    always_comb begin
        st_d = st_q;
        xfer = !load_n && clear_n;

        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_we[c]) begin
                case (kind)
                    WK_LOW:  st_d.inreg[c][BYTE_W-1:0] = wdata[BYTE_W-1:0];
                    WK_HIGH: st_d.inreg[c][CODE_W-1:BYTE_W] = wdata[HIGH_W-1:0];
                    default: st_d.inreg[c] = wdata;
                endcase
            end
            if (xfer) st_d.latch[c] = st_d.inreg[c];
        end

        for (int g = 0; g < NUM_GRP; g++) begin
            if (!clear_n)  st_d.clr[g] = 1'b1;
            else if (xfer) st_d.clr[g] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.inreg <= '0;
            st_q.latch <= '0;
            st_q.clr   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign latch_out = st_q.latch;
    assign clr_flag  = st_q.clr;

    assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n || !clear_n) |=> $stable(st_q.latch));
    assert_latch_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && clear_n) |=> (st_q.latch == st_q.inreg));
    assert_clear_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_n |=> (&st_q.clr));
    assert_clear_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((&st_q.clr) && (load_n || !clear_n)) |=> (&st_q.clr));
    assert_clear_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && clear_n) |=> (st_q.clr == '0));
endmodule

// File: rtl/dac_quad_loader.sv
module dac_quad_loader
    import dql_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CODE_W-1:0]        bus_data,
    input  logic                     cs_n,
    input  logic                     wr_n,
    input  logic                     byte_shift,
    input  logic                     narrow_bus,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     load_n,
    input  logic                     clear_n,
    output logic [NUM_CH*CODE_W-1:0] dac_code,
    output logic                     clr_grp_a,
    output logic                     clr_grp_b
);
    bus_ctl_t                      raw_ctl;
    bus_ctl_t                      sync_ctl;
    logic [NUM_CH-1:0]             ch_we;
    wkind_e                        kind;
    logic [CODE_W-1:0]             wdata;
    logic [NUM_CH-1:0][CODE_W-1:0] latch_out;
    logic [NUM_GRP-1:0]            clr_flag;

    always_comb begin
        raw_ctl.cs_n    = cs_n;
        raw_ctl.wr_n    = wr_n;
        raw_ctl.shift   = byte_shift;
        raw_ctl.narrow  = narrow_bus;
        raw_ctl.load_n  = load_n;
        raw_ctl.clear_n = clear_n;
        raw_ctl.addr    = addr;
        raw_ctl.data    = bus_data;
    end

    dql_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (raw_ctl),
        .synced (sync_ctl)
    );

    dql_write_decode i_decode (
        .clk   (clk),
        .rst_n (rst_n),
        .cur   (sync_ctl),
        .ch_we (ch_we),
        .kind  (kind),
        .wdata (wdata)
    );

    dql_latch_bank i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .ch_we     (ch_we),
        .kind      (kind),
        .wdata     (wdata),
        .load_n    (sync_ctl.load_n),
        .clear_n   (sync_ctl.clear_n),
        .latch_out (latch_out),
        .clr_flag  (clr_flag)
    );

    assign dac_code  = latch_out;
    assign clr_grp_a = clr_flag[0];
    assign clr_grp_b = clr_flag[NUM_GRP-1];
endmodule

// File: tb/test_dac_quad_loader.sv
module test_dac_quad_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] bus_data = '0;
    logic        cs_n = 1'b1, wr_n = 1'b1, byte_shift = 1'b1, narrow_bus = 1'b0;
    logic [2:0]  addr = '0;
    logic        load_n = 1'b1, clear_n = 1'b1;
    logic [55:0] dac_code;
    logic        clr_grp_a, clr_grp_b;

    int compared = 0;
    int mismatched = 0;
    logic [13:0] exp_in  [4];
    logic [13:0] exp_lat [4];
    logic        exp_clr;

    always #5 clk = ~clk;

    dac_quad_loader i_dac_quad_loader (
        .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .cs_n(cs_n), .wr_n(wr_n),
        .byte_shift(byte_shift), .narrow_bus(narrow_bus), .addr(addr),
        .load_n(load_n), .clear_n(clear_n), .dac_code(dac_code),
        .clr_grp_a(clr_grp_a), .clr_grp_b(clr_grp_b)
    );

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    task automatic check(input string req);
        for (int c = 0; c < 4; c++) begin
            compared++;
            if (dac_code[c*14 +: 14] !== exp_lat[c]) begin
                mismatched++;
                $display("FAIL %s ch%0d latch actual %h expected %h", req, c,
                         dac_code[c*14 +: 14], exp_lat[c]);
            end
        end
        compared++;
        if (clr_grp_a !== exp_clr || clr_grp_b !== exp_clr) begin
            mismatched++;
            $display("FAIL %s clear flags actual %b%b expected %b%b", req,
                     clr_grp_a, clr_grp_b, exp_clr, exp_clr);
        end
    endtask

    // R3 R4 R2 model: merge into expected input registers, R5 addressing
    task automatic model_write(input logic [2:0] a, input logic [13:0] d,
                               input logic nb, input logic sh);
        for (int c = 0; c < 4; c++) begin
            if (a[2] || a[1:0] == c[1:0]) begin
                if (!nb)    exp_in[c] = d;
                else if (sh) exp_in[c][7:0] = d[7:0];
                else         exp_in[c][13:8] = d[5:0];
                if (!load_n && clear_n) exp_lat[c] = exp_in[c];
            end
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [13:0] d,
                             input logic nb, input logic sh, input logic sel);
        @(negedge clk);
        addr = a; bus_data = d; narrow_bus = nb; byte_shift = sh; cs_n = !sel;
        repeat (3) @(negedge clk);
        wr_n = 1'b0;
        repeat (4) @(negedge clk);
        wr_n = 1'b1;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        if (sel) model_write(a, d, nb, sh);
        settle();
    endtask

    task automatic pulse_load();
        load_n = 1'b0;
        settle();
        if (clear_n) begin
            for (int c = 0; c < 4; c++) exp_lat[c] = exp_in[c];
            exp_clr = 1'b0;
        end
        load_n = 1'b1;
        settle();
    endtask

    initial begin
        #2_000_000;
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        for (int c = 0; c < 4; c++) begin exp_in[c] = '0; exp_lat[c] = '0; end
        exp_clr = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        check("R10 reset");

        pulse_load();
        check("R9 release after load");

        // R2 R5 R6: full-width writes to each address, latches must hold
        for (int a = 0; a < 8; a++) begin
            for (int p = 0; p < 3; p++) begin
                bus_write(3'(a), 14'((a * 1237 + p * 4099 + 5) & 16'h3fff), 1'b0, 1'b1, 1'b1);
                check("R6 hold during write");
                pulse_load();
                check("R2 R5 full write and load");
            end
        end

        // R1: write with chip select high changes nothing
        bus_write(3'd1, 14'h2aaa, 1'b0, 1'b1, 1'b0);
        pulse_load();
        check("R1 no write without cs");

        // R3 R4: byte loads on every channel
        for (int c = 0; c < 4; c++) begin
            for (int p = 0; p < 4; p++) begin
                bus_write(3'(c), 14'((8'h5a ^ (c * 37 + p * 71)) & 8'hff), 1'b1, 1'b1, 1'b1);
                bus_write(3'(c), 14'((8'hc0 | (c * 13 + p * 9)) & 8'hff), 1'b1, 1'b0, 1'b1);
                pulse_load();
                check("R3 R4 byte load");
            end
        end
        bus_write(3'd6, 14'h3f3c, 1'b1, 1'b0, 1'b1);
        pulse_load();
        check("R4 R5 broadcast high byte");

        // R7: immediate update with load held low
        load_n = 1'b0;
        settle();
        for (int c = 0; c < 4; c++) exp_lat[c] = exp_in[c];
        for (int a = 0; a < 4; a++) begin
            bus_write(3'(a), 14'(16'h1111 * (a + 1)), 1'b0, 1'b1, 1'b1);
            check("R7 immediate update");
        end

        // R8: clear low sets flags, load ignored
        clear_n = 1'b0;
        exp_clr = 1'b1;
        settle();
        check("R8 clear sets flags");
        bus_write(3'd2, 14'h0bad, 1'b0, 1'b1, 1'b1);
        check("R8 latch held while clear");

        // R9: flags stay after clear release until load low
        load_n = 1'b1;
        settle();
        clear_n = 1'b1;
        settle();
        check("R9 flags sticky");
        pulse_load();
        check("R9 flags release and latch update");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule